// File: doc/BRIEF.md
# Processor Mode and Privilege Tracker

This block follows the operating mode of an x86-style core and its current privilege level (CPL). It owns the control register that carries the protection-enable and paging-enable bits. Each cycle it samples the virtual-8086 flag from the flags logic and decides from both which of three modes the core runs in: real, protected or virtual-8086.

CPL is not a free-running copy of any input. It changes only when the mode changes, and the new mode sets the rule. Entering protected mode from real mode takes the privilege field of the stack-segment descriptor cache. Entering real mode forces privilege 0. Entering virtual-8086 mode forces privilege 3.

Ordinary control-register writes are screened. A write that asks for paging without protection is refused with a general-protection fault and an error code of zero. A separate state-restore load path installs any value unchecked.

Top module: `cpu_mode_tracker`

## Requirements
- R1: After reset is applied, the control register reads 0, mode is real (code 0), CPL is 0, paging is off and no fault is signalled.
- R2: Mode is chosen from the index {virtual-8086 flag, control bit 0}. Index 00 and 10 give real (code 0), 01 gives protected (code 1) and 11 gives virtual-8086 (code 2).
- R3: When the mode goes from real to protected, CPL takes the stack-descriptor DPL input present at that update edge.
- R4: Whenever the mode changes into real, CPL becomes 0.
- R5: Whenever the mode changes into virtual-8086, CPL becomes 3.
- R6: While the mode does not change, CPL holds, and changes of the DPL input have no effect. A change from virtual-8086 to protected also leaves CPL as it was.
- R7: Paging is reported active only when control bit 31 is set and the current mode is not real.
- R8: A normal write whose data has bit 31 set and bit 0 clear raises the fault output in the same cycle as the request, with a 16-bit error code of 0. The control register keeps its previous value.
- R9: A restore load installs its data unchecked, including bit 31 set with bit 0 clear, and never raises the fault. If a restore and a normal write arrive in the same cycle, the restore wins and the write is dropped.
- R10: An accepted write is visible on the control register output after the next clock edge. Mode and CPL follow one clock edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vm_flag | input | 1 | Virtual-8086 flag from the flags logic |
| ss_dpl | input | 2 | DPL field of the stack-segment descriptor cache |
| wr_req | input | 1 | Normal control-register write request |
| wr_data | input | 32 | Data for the normal write |
| restore_req | input | 1 | Unchecked restore load request |
| restore_data | input | 32 | Data for the restore load |
| cr_value | output | 32 | Current control register contents |
| mode | output | 2 | Current mode: 0 real, 1 protected, 2 virtual-8086 |
| cpl | output | 2 | Current privilege level |
| paging_on | output | 1 | Paging active |
| gp_fault | output | 1 | General-protection fault pulse for a refused write |
| gp_err | output | 16 | Fault error code, always zero |

## Verification
The bench builds the block with its default parameters: a 32-bit register, enable bits 0 and 31, a 2-bit privilege level and a two-stage reset synchronizer. With a 2-bit DPL and a 2-bit mode index, this configuration is small enough to sweep every start index, every target index, every DPL value and both paging settings. That reaches every mode transition the rules name. It also reaches the refused paging-without-protection write from each mode and the unchecked restore of the same value.

// File: rtl/cpu_mode_pkg.sv
package cpu_mode_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_PROT = 2'b01,
    MODE_V86  = 2'b10
  } cpu_mode_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cr_write_ctrl.sv
module cr_write_ctrl #(
  parameter int XLEN   = 32,
  parameter int PE_BIT = 0,
  parameter int PG_BIT = 31,
  parameter int ERR_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic [XLEN-1:0] wr_data,
  input  logic            ld_req,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] cr_q,
  output logic            fault,
  output logic [ERR_W-1:0] err_code
);
  logic            illegal;
  logic            cr_en;
  logic [XLEN-1:0] cr_d;

  always_comb begin
    illegal  = wr_data[PG_BIT] & ~wr_data[PE_BIT];
    fault    = wr_req & ~ld_req & illegal;
    err_code = '0;
    cr_en    = ld_req | (wr_req & ~illegal);
    cr_d     = ld_req ? ld_data : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cr_q <= '0;
    else if (cr_en) cr_q <= cr_d;
  end
endmodule

// File: rtl/mode_select.sv
module mode_select
  import cpu_mode_pkg::*;
(
  input  logic      vm,
  input  logic      pe,
  output cpu_mode_e mode_new
);
  always_comb begin
    unique case ({vm, pe})
      2'b01:   mode_new = MODE_PROT;
      2'b11:   mode_new = MODE_V86;
      default: mode_new = MODE_REAL;
    endcase
  end
endmodule

// File: rtl/mode_cpl_reg.sv
module mode_cpl_reg
  import cpu_mode_pkg::*;
#(
  parameter int CPL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cpu_mode_e        mode_new,
  input  logic [CPL_W-1:0] dpl,
  output cpu_mode_e        mode_q,
  output logic [CPL_W-1:0] cpl_q
);
  localparam logic [CPL_W-1:0] CPL_KERNEL = '0;
  localparam logic [CPL_W-1:0] CPL_USER   = '1;

  cpu_mode_e        mode_d;
  logic [CPL_W-1:0] cpl_d;
  logic             upd_en;

  always_comb begin
    upd_en = (mode_new != mode_q);
    mode_d = mode_new;
    cpl_d  = cpl_q;
    if (mode_q == MODE_REAL && mode_new == MODE_PROT) cpl_d = dpl;
    else if (mode_new == MODE_REAL)                   cpl_d = CPL_KERNEL;
    else if (mode_new == MODE_V86)                    cpl_d = CPL_USER;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_REAL;
      cpl_q  <= CPL_KERNEL;
    end else if (upd_en) begin
      mode_q <= mode_d;
      cpl_q  <= cpl_d;
    end
  end
endmodule

// File: rtl/cpu_mode_tracker.sv
module cpu_mode_tracker
  import cpu_mode_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int PE_BIT      = 0,
  parameter int PG_BIT      = 31,
  parameter int CPL_W       = 2,
  parameter int ERR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vm_flag,
  input  logic [CPL_W-1:0] ss_dpl,
  input  logic             wr_req,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             restore_req,
  input  logic [XLEN-1:0]  restore_data,
  output logic [XLEN-1:0]  cr_value,
  output logic [1:0]       mode,
  output logic [CPL_W-1:0] cpl,
  output logic             paging_on,
  output logic             gp_fault,
  output logic [ERR_W-1:0] gp_err
);
  logic      rst_i_n;
  logic      vm_q;
  cpu_mode_e mode_new;
  cpu_mode_e mode_q;

  rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  cr_write_ctrl #(.XLEN(XLEN), .PE_BIT(PE_BIT), .PG_BIT(PG_BIT), .ERR_W(ERR_W)) u_cr (
    .clk(clk), .rst_n(rst_i_n),
    .wr_req(wr_req), .wr_data(wr_data),
    .ld_req(restore_req), .ld_data(restore_data),
    .cr_q(cr_value), .fault(gp_fault), .err_code(gp_err)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) vm_q <= 1'b0;
    else          vm_q <= vm_flag;
  end

  mode_select u_sel (
    .vm(vm_q), .pe(cr_value[PE_BIT]), .mode_new(mode_new)
  );

  mode_cpl_reg #(.CPL_W(CPL_W)) u_mc (
    .clk(clk), .rst_n(rst_i_n), .mode_new(mode_new), .dpl(ss_dpl),
    .mode_q(mode_q), .cpl_q(cpl)
  );

  assign mode      = mode_q;
  assign paging_on = cr_value[PG_BIT] & (mode_q != MODE_REAL);
endmodule

// File: rtl/mode_tracker_chk.sv
module mode_tracker_chk #(
  parameter int XLEN  = 32,
  parameter int CPL_W = 2,
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CPL_W-1:0] ss_dpl,
  input logic             wr_req,
  input logic [XLEN-1:0]  wr_data,
  input logic             restore_req,
  input logic [XLEN-1:0]  cr_value,
  input logic [1:0]       mode,
  input logic [CPL_W-1:0] cpl,
  input logic             paging_on,
  input logic             gp_fault,
  input logic [ERR_W-1:0] gp_err
);
  a_r4_real_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |-> cpl == '0);

  a_r5_v86_user: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> cpl == '1);

  a_r3_enter_prot: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b00 && mode == 2'b01) |-> cpl == $past(ss_dpl));

  a_r6_prot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b01 && mode == 2'b01) |-> $stable(cpl));

  a_r7_paging: assert property (@(posedge clk) disable iff (!rst_n)
    paging_on |-> (mode != 2'b00 && cr_value[XLEN-1]));

  a_r8_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !restore_req && wr_data[XLEN-1] && !wr_data[0]) |-> (gp_fault && gp_err == '0));

  a_r8_reg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |=> $stable(cr_value));

  a_r9_restore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |-> !gp_fault);

  a_r2_mode_code: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);
endmodule

bind cpu_mode_tracker mode_tracker_chk #(.XLEN(XLEN), .CPL_W(CPL_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_dpl(ss_dpl), .wr_req(wr_req), .wr_data(wr_data),
  .restore_req(restore_req), .cr_value(cr_value), .mode(mode), .cpl(cpl),
  .paging_on(paging_on), .gp_fault(gp_fault), .gp_err(gp_err)
);

// File: tb/tb_cpu_mode_tracker.sv
module tb_cpu_mode_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vm_flag;
  logic [1:0]  ss_dpl;
  logic        wr_req;
  logic [31:0] wr_data;
  logic        restore_req;
  logic [31:0] restore_data;
  logic [31:0] cr_value;
  logic [1:0]  mode;
  logic [1:0]  cpl;
  logic        paging_on;
  logic        gp_fault;
  logic [15:0] gp_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] exp_cr;
  int          exp_mode;
  int          exp_cpl;

  always #5 clk = ~clk;

  cpu_mode_tracker dut (
    .clk(clk), .rst_n(rst_n), .vm_flag(vm_flag), .ss_dpl(ss_dpl),
    .wr_req(wr_req), .wr_data(wr_data), .restore_req(restore_req),
    .restore_data(restore_data), .cr_value(cr_value), .mode(mode), .cpl(cpl),
    .paging_on(paging_on), .gp_fault(gp_fault), .gp_err(gp_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One request, then follow the two edges to the settled state.
  task automatic drive(input bit vm, input bit do_wr, input logic [31:0] wd,
                       input bit do_ld, input logic [31:0] ld, input logic [1:0] dpl);
    bit illegal;
    bit exp_fault;
    int new_mode;
    int old_mode;
    @(negedge clk);
    vm_flag = vm; ss_dpl = dpl;
    wr_req = do_wr; wr_data = wd;
    restore_req = do_ld; restore_data = ld;
    illegal   = wd[31] && !wd[0];
    exp_fault = do_wr && !do_ld && illegal;
    #1;
    chk("R8 fault pulse", {31'b0, gp_fault}, {31'b0, exp_fault});
    if (exp_fault) chk("R8 error code", {16'b0, gp_err}, 32'h0);
    if (do_ld)     chk("R9 restore no fault", {31'b0, gp_fault}, 32'h0);
    if (do_ld)             exp_cr = ld;
    else if (do_wr && !illegal) exp_cr = wd;
    @(negedge clk);
    wr_req = 1'b0; restore_req = 1'b0;
    chk("R10 register after one edge", cr_value, exp_cr);
    chk("R10 mode not yet moved", {30'b0, mode}, exp_mode);
    old_mode = exp_mode;
    new_mode = (vm && exp_cr[0]) ? 2 : (exp_cr[0] ? 1 : 0);
    if (new_mode != old_mode) begin
      if (old_mode == 0 && new_mode == 1) exp_cpl = dpl;
      else if (new_mode == 0)             exp_cpl = 0;
      else if (new_mode == 2)             exp_cpl = 3;
      exp_mode = new_mode;
    end
    @(negedge clk);
    chk("R2 mode", {30'b0, mode}, exp_mode);
    if (old_mode == 0 && exp_mode == 1)      chk("R3 cpl from dpl", {30'b0, cpl}, exp_cpl);
    else if (old_mode != 0 && exp_mode == 0) chk("R4 cpl forced 0", {30'b0, cpl}, exp_cpl);
    else if (old_mode != 2 && exp_mode == 2) chk("R5 cpl forced 3", {30'b0, cpl}, exp_cpl);
    else                                     chk("R6 cpl held", {30'b0, cpl}, exp_cpl);
    chk("R7 paging", {31'b0, paging_on}, {31'b0, (exp_cr[31] && exp_mode != 0)});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; vm_flag = 1'b0; ss_dpl = 2'd0;
    wr_req = 1'b0; wr_data = '0; restore_req = 1'b0; restore_data = '0;
    exp_cr = '0; exp_mode = 0; exp_cpl = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset cr", cr_value, 32'h0);
    chk("R1 reset mode", {30'b0, mode}, 32'h0);
    chk("R1 reset cpl", {30'b0, cpl}, 32'h0);
    chk("R1 reset paging", {31'b0, paging_on}, 32'h0);
    chk("R1 reset fault", {31'b0, gp_fault}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Sweep: every start index, every target index, every dpl, both PG values.
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int d = 0; d < 4; d++)
          for (int p = 0; p < 2; p++) begin
            drive(a[1], 1'b1, {31'b0, a[0]}, 1'b0, 32'h0, d[1:0]);
            drive(b[1], 1'b1, {p[0], 30'b0, b[0]}, 1'b0, 32'h0, 2'(3 - d));
          end

    // R6: protected persists while the DPL input moves.
    drive(1'b0, 1'b1, 32'h0, 1'b0, 32'h0, 2'd0);
    drive(1'b0, 1'b1, 32'h1, 1'b0, 32'h0, 2'd2);
    for (int d = 0; d < 4; d++) begin
      drive(1'b0, 1'b1, 32'h1, 1'b0, 32'h0, d[1:0]);
      chk("R6 prot keeps cpl 2", {30'b0, cpl}, 32'd2);
    end

    // R9: restore installs PG without PE, from protected mode.
    drive(1'b0, 1'b0, 32'h0, 1'b1, 32'h8000_0000, 2'd1);
    chk("R9 restored value", cr_value, 32'h8000_0000);
    chk("R9 real after restore", {30'b0, mode}, 32'h0);
    chk("R9 cpl 0 after restore", {30'b0, cpl}, 32'h0);
    // R8: normal write of the same value from protected mode is refused.
    drive(1'b0, 1'b1, 32'h8000_0001, 1'b0, 32'h0, 2'd1);
    drive(1'b0, 1'b1, 32'h8000_0000, 1'b0, 32'h0, 2'd1);
    chk("R8 register kept", cr_value, 32'h8000_0001);
    chk("R8 still protected", {30'b0, mode}, 32'h1);
    // R9: restore wins over a simultaneous write.
    drive(1'b0, 1'b1, 32'h0000_0001, 1'b1, 32'h8000_0000, 2'd3);
    chk("R9 restore priority", cr_value, 32'h8000_0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule